// File: doc/BRIEF.md
# Paged Descriptor Ring Index Manager

This block keeps the running indices of three circular descriptor rings that sit in host memory: a request ring the device drains, a completion ring it fills, and a message ring it posts notifications on. Each ring is made of several physical pages. A page-table write port loads the frame number of every page. A setup strobe then fixes the page count of the request and completion rings, and a second strobe fixes the page count of the message ring. The block does no memory traffic of its own. It turns each local counter into the byte address of the next descriptor. It also raises publish pulses that carry the index values the surrounding logic must store into the shared ring-state page.

A ring holds pages × entries-per-page descriptors. The counter is masked to a power-of-two window whose width is the bit length of (entries − 1). The page is chosen by dividing the masked index by the entries per page. The remainder, scaled by the descriptor size, is added to that page's frame number shifted left by 12. Each ring has its own flow-control rule. A request is offered only when the shared producer index shows new work within the largest possible request ring. Completions advance with no overflow check. A message is posted only when the shared producer and consumer indices show a free slot.

Top module: `desc_ring_idx`

## Requirements
- R1: A ring's entry count is pages × entries-per-page (request 32, completion 128, message 32). Its log2 output is the number of significant bits of (entry count − 1), and the wrap mask is all ones over that many bits.
- R2: An accepted data setup (both page counts within 1..8) gives, one cycle later, setup_done=1, data_ready=1, request and completion counters at zero, and init_pulse bits 0 (request) and 1 (completion) high. The message ring state is left as it was.
- R3: A setup whose page count is zero or above its limit (8 for the data rings, 4 for the message ring) gives setup_err=1 one cycle later and changes no ready flag, log2 value or counter.
- R4: req_avail is high only while data_ready=1, req_prod_sh differs from the consumed count, and (req_prod_sh − consumed) modulo 2^32 is below 256. req_take advances the consumed count only when req_avail is high.
- R5: Each ring address is (frame[masked/EPP] << 12) + (masked % EPP) × descriptor size. Descriptor sizes are 128 bytes for request and message and 32 bytes for completion. The page-table port selects the ring with pt_ring: 0 request, 1 completion, 2 message.
- R6: req_flush gives req_cons_wb_vld one cycle later, carrying the consumed count.
- R7: cmp_put advances the completion count whenever data_ready=1, with no fullness check. cmp_flush gives cmp_prod_wb_vld one cycle later, carrying the filled count.
- R8: msg_room is high when msg_ready=1 and (msg_prod_sh − msg_cons_sh) modulo 2^32 is below mask+1. A msg_put with room advances the count, and one cycle later msg_prod_wb_vld carries the new count. A msg_put without room changes nothing.
- R9: A message setup while data_ready=0 is ignored: no done, no error, and msg_ready stays low. An accepted message setup raises init_pulse bit 2 and clears the message count.
- R10: clr clears ready flags, counters, log2 values and all page-table entries.
- R11: After reset no ring is ready, no request is available, no message room is shown, and no pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous full cleanup |
| pt_we | input | 1 | Page-table write strobe |
| pt_ring | input | 2 | Ring selected for the write (0 req, 1 cmp, 2 msg) |
| pt_idx | input | 3 | Page slot written |
| pt_pfn | input | PFN_W | Page frame number |
| setup_data | input | 1 | Data-ring setup strobe |
| cfg_req_pages | input | 8 | Request ring page count |
| cfg_cmp_pages | input | 8 | Completion ring page count |
| setup_msg | input | 1 | Message-ring setup strobe |
| cfg_msg_pages | input | 8 | Message ring page count |
| setup_done | output | 1 | Setup accepted pulse |
| setup_err | output | 1 | Setup rejected pulse |
| data_ready | output | 1 | Request and completion rings configured |
| msg_ready | output | 1 | Message ring configured |
| init_pulse | output | 3 | Per ring: publish producer=0, consumer=0 and log2 |
| req_log2 | output | 6 | Request ring log2 entry count |
| cmp_log2 | output | 6 | Completion ring log2 entry count |
| msg_log2 | output | 6 | Message ring log2 entry count |
| req_prod_sh | input | 32 | Shared request producer index |
| req_take | input | 1 | Consume the offered request |
| req_avail | output | 1 | A request descriptor is available |
| req_addr | output | PFN_W+12 | Address of the next request descriptor |
| req_flush | input | 1 | Publish the request consumer index |
| req_cons_wb_vld | output | 1 | Request consumer publish pulse |
| req_cons_wb | output | 32 | Value to publish |
| cmp_put | input | 1 | Fill one completion slot |
| cmp_addr | output | PFN_W+12 | Address of the next completion slot |
| cmp_flush | input | 1 | Publish the completion producer index |
| cmp_prod_wb_vld | output | 1 | Completion producer publish pulse |
| cmp_prod_wb | output | 32 | Value to publish |
| msg_prod_sh | input | 32 | Shared message producer index |
| msg_cons_sh | input | 32 | Shared message consumer index |
| msg_put | input | 1 | Post one message |
| msg_room | output | 1 | The message ring has a free slot |
| msg_addr | output | PFN_W+12 | Address of the next message slot |
| msg_prod_wb_vld | output | 1 | Message producer publish pulse |
| msg_prod_wb | output | 32 | Value to publish |

## Verification
A wrong mask width or page split appears as a wrong address. It shows as soon as a counter crosses a page boundary or the wrap point, so the bench drives each counter past both. A consumed or filled count that has drifted appears in the address the next cycle, and in the next publish pulse. A wrong availability comparison shows only at its edges, so the bench sets the producer–consumer gaps at exactly 255, 256, 127 and 128, and also across the 2^32 wrap. A cleanup that misses state appears when a fresh setup still shows stale page frames.

// File: rtl/desc_ring_idx_pkg.sv
package desc_ring_idx_pkg;

  typedef enum logic [1:0] {
    RING_REQ = 2'd0,
    RING_CMP = 2'd1,
    RING_MSG = 2'd2
  } ring_e;

  localparam int NUM_RINGS = 3;

  // bit length of a value (0 for 0)
  function automatic logic [5:0] bit_len(input logic [31:0] v);
    logic [5:0] n;
    n = 6'd0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) n = 6'(i + 1);
    end
    return n;
  endfunction

  function automatic logic [31:0] ones_below(input logic [5:0] w);
    if (w >= 6'd32) return 32'hFFFF_FFFF;
    return (32'd1 << w) - 32'd1;
  endfunction

endpackage

// File: rtl/desc_ring_lane.sv
module desc_ring_lane
  import desc_ring_idx_pkg::*;
#(
  parameter int EPP      = 32,
  parameter int DESC_B   = 128,
  parameter int MAXP     = 8,
  parameter int PFN_W    = 40,
  parameter int PG_SHIFT = 12,
  parameter int PT_IW    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      tw_en,
  input  logic [PT_IW-1:0]          tw_idx,
  input  logic [PFN_W-1:0]          tw_pfn,
  input  logic                      cfg_en,
  input  logic [7:0]                cfg_pages,
  input  logic [31:0]               cnt,
  output logic [PFN_W+PG_SHIFT-1:0] addr,
  output logic [5:0]                lg,
  output logic [31:0]               mask
);
  localparam int ADDR_W  = PFN_W + PG_SHIFT;
  localparam int EPP_SH  = $clog2(EPP);
  localparam int DESC_SH = $clog2(DESC_B);
  localparam int PIW     = (MAXP > 1) ? $clog2(MAXP) : 1;

  logic [PFN_W-1:0] tbl [MAXP];
  logic [5:0]       lg_q;
  logic [31:0]      idx, pg, off;
  logic [PFN_W-1:0] base_pfn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lg_q <= '0;
      for (int i = 0; i < MAXP; i++) tbl[i] <= '0;
    end else if (clr) begin
      lg_q <= '0;
      for (int i = 0; i < MAXP; i++) tbl[i] <= '0;
    end else begin
      if (tw_en && (32'(tw_idx) < MAXP)) tbl[tw_idx[PIW-1:0]] <= tw_pfn;
      if (cfg_en) lg_q <= bit_len(32'(cfg_pages) * 32'(EPP) - 32'd1);
    end
  end

  assign lg   = lg_q;
  assign mask = ones_below(lg_q);
  assign idx  = cnt & mask;
  assign pg   = idx >> EPP_SH;
  assign off  = idx & 32'(EPP - 1);
  assign base_pfn = (pg < MAXP) ? tbl[pg[PIW-1:0]] : '0;
  assign addr = ({base_pfn, {PG_SHIFT{1'b0}}}) + (ADDR_W'(off) << DESC_SH);

endmodule

// File: rtl/desc_ring_idx.sv
module desc_ring_idx
  import desc_ring_idx_pkg::*;
#(
  parameter int REQ_EPP   = 32,
  parameter int REQ_DESC  = 128,
  parameter int CMP_EPP   = 128,
  parameter int CMP_DESC  = 32,
  parameter int MSG_EPP   = 32,
  parameter int MSG_DESC  = 128,
  parameter int DATA_MAXP = 8,
  parameter int MSG_MAXP  = 4,
  parameter int PFN_W     = 40,
  parameter int PG_SHIFT  = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          pt_we,
  input  logic [1:0]                    pt_ring,
  input  logic [$clog2(DATA_MAXP)-1:0]  pt_idx,
  input  logic [PFN_W-1:0]              pt_pfn,
  input  logic                          setup_data,
  input  logic [7:0]                    cfg_req_pages,
  input  logic [7:0]                    cfg_cmp_pages,
  input  logic                          setup_msg,
  input  logic [7:0]                    cfg_msg_pages,
  output logic                          setup_done,
  output logic                          setup_err,
  output logic                          data_ready,
  output logic                          msg_ready,
  output logic [2:0]                    init_pulse,
  output logic [5:0]                    req_log2,
  output logic [5:0]                    cmp_log2,
  output logic [5:0]                    msg_log2,
  input  logic [31:0]                   req_prod_sh,
  input  logic                          req_take,
  output logic                          req_avail,
  output logic [PFN_W+PG_SHIFT-1:0]     req_addr,
  input  logic                          req_flush,
  output logic                          req_cons_wb_vld,
  output logic [31:0]                   req_cons_wb,
  input  logic                          cmp_put,
  output logic [PFN_W+PG_SHIFT-1:0]     cmp_addr,
  input  logic                          cmp_flush,
  output logic                          cmp_prod_wb_vld,
  output logic [31:0]                   cmp_prod_wb,
  input  logic [31:0]                   msg_prod_sh,
  input  logic [31:0]                   msg_cons_sh,
  input  logic                          msg_put,
  output logic                          msg_room,
  output logic [PFN_W+PG_SHIFT-1:0]     msg_addr,
  output logic                          msg_prod_wb_vld,
  output logic [31:0]                   msg_prod_wb
);
  localparam int ADDR_W = PFN_W + PG_SHIFT;
  localparam int PT_IW  = $clog2(DATA_MAXP);
  localparam logic [31:0] REQ_CAP = 32'(DATA_MAXP * REQ_EPP);

  logic [31:0]       cnt_q   [NUM_RINGS];
  logic [ADDR_W-1:0] ln_addr [NUM_RINGS];
  logic [5:0]        ln_lg   [NUM_RINGS];
  logic [31:0]       ln_mask [NUM_RINGS];
  logic              ln_cfg  [NUM_RINGS];

  // named internal events
  logic        data_pages_ok, msg_pages_ok;
  logic        data_acc, data_rej, msg_acc, msg_rej;
  logic        req_fire, cmp_fire, msg_fire;
  logic [31:0] req_gap, msg_gap;
  logic [31:0] cons_nxt, cmp_nxt, msg_nxt;

  assign data_pages_ok = (cfg_req_pages != 8'd0) && (32'(cfg_req_pages) <= DATA_MAXP) &&
                         (cfg_cmp_pages != 8'd0) && (32'(cfg_cmp_pages) <= DATA_MAXP);
  assign msg_pages_ok  = (cfg_msg_pages != 8'd0) && (32'(cfg_msg_pages) <= MSG_MAXP);
  assign data_acc = setup_data && data_pages_ok;
  assign data_rej = setup_data && !data_pages_ok;
  assign msg_acc  = setup_msg && data_ready && msg_pages_ok;
  assign msg_rej  = setup_msg && data_ready && !msg_pages_ok;

  assign ln_cfg[0] = data_acc;
  assign ln_cfg[1] = data_acc;
  assign ln_cfg[2] = msg_acc;

  generate
    for (genvar k = 0; k < NUM_RINGS; k++) begin : g_lane
      localparam int EPP_K  = (k == 0) ? REQ_EPP  : ((k == 1) ? CMP_EPP  : MSG_EPP);
      localparam int DESC_K = (k == 0) ? REQ_DESC : ((k == 1) ? CMP_DESC : MSG_DESC);
      localparam int MAXP_K = (k == 2) ? MSG_MAXP : DATA_MAXP;
      desc_ring_lane #(
        .EPP(EPP_K), .DESC_B(DESC_K), .MAXP(MAXP_K),
        .PFN_W(PFN_W), .PG_SHIFT(PG_SHIFT), .PT_IW(PT_IW)
      ) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .tw_en    (pt_we && (pt_ring == 2'(k))),
        .tw_idx   (pt_idx),
        .tw_pfn   (pt_pfn),
        .cfg_en   (ln_cfg[k]),
        .cfg_pages((k == 0) ? cfg_req_pages : ((k == 1) ? cfg_cmp_pages : cfg_msg_pages)),
        .cnt      (cnt_q[k]),
        .addr     (ln_addr[k]),
        .lg       (ln_lg[k]),
        .mask     (ln_mask[k])
      );
    end
  endgenerate

  assign req_gap   = req_prod_sh - cnt_q[RING_REQ];
  assign req_avail = data_ready && (req_gap != 32'd0) && (req_gap < REQ_CAP);
  assign msg_gap   = msg_prod_sh - msg_cons_sh;
  assign msg_room  = msg_ready && (msg_gap < (ln_mask[RING_MSG] + 32'd1));

  assign req_fire = req_take && req_avail;
  assign cmp_fire = cmp_put && data_ready;
  assign msg_fire = msg_put && msg_room;

  assign cons_nxt = cnt_q[RING_REQ] + 32'(req_fire);
  assign cmp_nxt  = cnt_q[RING_CMP] + 32'(cmp_fire);
  assign msg_nxt  = cnt_q[RING_MSG] + 32'(msg_fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_RINGS; i++) cnt_q[i] <= '0;
      data_ready <= 1'b0; msg_ready <= 1'b0;
      setup_done <= 1'b0; setup_err <= 1'b0; init_pulse <= '0;
      req_cons_wb_vld <= 1'b0; req_cons_wb <= '0;
      cmp_prod_wb_vld <= 1'b0; cmp_prod_wb <= '0;
      msg_prod_wb_vld <= 1'b0; msg_prod_wb <= '0;
    end else if (clr) begin
      for (int i = 0; i < NUM_RINGS; i++) cnt_q[i] <= '0;
      data_ready <= 1'b0; msg_ready <= 1'b0;
      setup_done <= 1'b0; setup_err <= 1'b0; init_pulse <= '0;
      req_cons_wb_vld <= 1'b0; req_cons_wb <= '0;
      cmp_prod_wb_vld <= 1'b0; cmp_prod_wb <= '0;
      msg_prod_wb_vld <= 1'b0; msg_prod_wb <= '0;
    end else begin
      setup_done <= data_acc || msg_acc;
      setup_err  <= data_rej || msg_rej;
      init_pulse <= {msg_acc, data_acc, data_acc};
      if (data_acc) begin
        data_ready      <= 1'b1;
        cnt_q[RING_REQ] <= '0;
        cnt_q[RING_CMP] <= '0;
      end else begin
        cnt_q[RING_REQ] <= cons_nxt;
        cnt_q[RING_CMP] <= cmp_nxt;
      end
      if (msg_acc) begin
        msg_ready       <= 1'b1;
        cnt_q[RING_MSG] <= '0;
      end else begin
        cnt_q[RING_MSG] <= msg_nxt;
      end
      req_cons_wb_vld <= req_flush && data_ready;
      if (req_flush) req_cons_wb <= cons_nxt;
      cmp_prod_wb_vld <= cmp_flush && data_ready;
      if (cmp_flush) cmp_prod_wb <= cmp_nxt;
      msg_prod_wb_vld <= msg_fire;
      if (msg_fire) msg_prod_wb <= msg_nxt;
    end
  end

  assign req_addr = ln_addr[RING_REQ];
  assign cmp_addr = ln_addr[RING_CMP];
  assign msg_addr = ln_addr[RING_MSG];
  assign req_log2 = ln_lg[RING_REQ];
  assign cmp_log2 = ln_lg[RING_CMP];
  assign msg_log2 = ln_lg[RING_MSG];

endmodule

// File: rtl/desc_ring_idx_chk.sv
module desc_ring_idx_chk #(
  parameter int REQ_DESC = 128,
  parameter int PFN_W    = 40,
  parameter int PG_SHIFT = 12
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      clr,
  input logic                      setup_done,
  input logic                      setup_err,
  input logic                      data_ready,
  input logic                      msg_ready,
  input logic [2:0]                init_pulse,
  input logic [5:0]                req_log2,
  input logic                      req_avail,
  input logic [PFN_W+PG_SHIFT-1:0] req_addr,
  input logic                      msg_room,
  input logic                      msg_put,
  input logic                      msg_prod_wb_vld
);
  localparam int RDSH = $clog2(REQ_DESC);

  // R4
  avail_needs_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_avail |-> data_ready);

  // R8
  room_needs_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_room |-> msg_ready);

  // R3
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(setup_done && setup_err));

  // R10
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!data_ready && !msg_ready && (init_pulse == 3'b000)));

  // R5
  req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_avail |-> (req_addr[RDSH-1:0] == '0));

  // R8
  msg_pub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_put && msg_room && !clr) |=> msg_prod_wb_vld);

  // R1
  init_log2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse[0] |-> (req_log2 != 6'd0));

endmodule

bind desc_ring_idx desc_ring_idx_chk #(
  .REQ_DESC(REQ_DESC), .PFN_W(PFN_W), .PG_SHIFT(PG_SHIFT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr),
  .setup_done(setup_done), .setup_err(setup_err),
  .data_ready(data_ready), .msg_ready(msg_ready),
  .init_pulse(init_pulse), .req_log2(req_log2),
  .req_avail(req_avail), .req_addr(req_addr),
  .msg_room(msg_room), .msg_put(msg_put),
  .msg_prod_wb_vld(msg_prod_wb_vld)
);

// File: tb/sim_desc_ring_idx.sv
`timescale 1ns/1ps
module sim_desc_ring_idx;
  localparam int PFN_W = 40;
  localparam int AW    = PFN_W + 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 0, pt_we = 0, setup_data = 0, setup_msg = 0;
  logic [1:0] pt_ring = 0;
  logic [2:0] pt_idx = 0;
  logic [PFN_W-1:0] pt_pfn = 0;
  logic [7:0] cfg_req_pages = 0, cfg_cmp_pages = 0, cfg_msg_pages = 0;
  logic setup_done, setup_err, data_ready, msg_ready;
  logic [2:0] init_pulse;
  logic [5:0] req_log2, cmp_log2, msg_log2;
  logic [31:0] req_prod_sh = 0, msg_prod_sh = 0, msg_cons_sh = 0;
  logic req_take = 0, req_flush = 0, cmp_put = 0, cmp_flush = 0, msg_put = 0;
  logic req_avail, req_cons_wb_vld, cmp_prod_wb_vld, msg_room, msg_prod_wb_vld;
  logic [AW-1:0] req_addr, cmp_addr, msg_addr;
  logic [31:0] req_cons_wb, cmp_prod_wb, msg_prod_wb;

  always #2.5 clk = ~clk;

  desc_ring_idx u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  longint unsigned m_pfn [3][8];
  int m_pages [3];
  int unsigned m_cnt [3];

  task automatic chk(input string rq, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cyc;
    @(posedge clk); #1;
  endtask

  function automatic int sigbits(input int unsigned x);
    int r = 0;
    for (int i = 0; i < 32; i++) if ((x >> i) & 1) r = i + 1;
    return r;
  endfunction

  function automatic longint unsigned exp_addr(input int r, input int unsigned c);
    int epp  = (r == 1) ? 128 : 32;
    int desc = (r == 1) ? 32 : 128;
    int lg   = sigbits(m_pages[r] * epp - 1);
    int unsigned i = c & ((lg >= 32) ? 32'hFFFF_FFFF : ((32'd1 << lg) - 1));
    return (m_pfn[r][i / epp] << 12) + longint'((i % epp) * desc);
  endfunction

  task automatic do_setup_data(input int rp, input int cp);
    cfg_req_pages = 8'(rp); cfg_cmp_pages = 8'(cp); setup_data = 1;
    cyc; setup_data = 0;
  endtask

  task automatic do_setup_msg(input int mp);
    cfg_msg_pages = 8'(mp); setup_msg = 1;
    cyc; setup_msg = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc;
    // R11 reset state
    chk("R11 data_ready", data_ready, 0);
    chk("R11 msg_ready", msg_ready, 0);
    chk("R11 req_avail", req_avail, 0);
    chk("R11 msg_room", msg_room, 0);
    chk("R11 pulses", {setup_done, setup_err, init_pulse}, 0);

    // R5 load page tables (pt_ring 0 req, 1 cmp, 2 msg)
    for (int r = 0; r < 3; r++)
      for (int i = 0; i < 8; i++) begin
        pt_we = 1; pt_ring = 2'(r); pt_idx = 3'(i);
        pt_pfn = {8'($urandom), 32'($urandom)};
        m_pfn[r][i] = pt_pfn;
        cyc;
      end
    pt_we = 0;

    // R9 message setup before data rings: ignored
    do_setup_msg(2);
    chk("R9 no done", setup_done, 0);
    chk("R9 no err", setup_err, 0);
    chk("R9 msg_ready low", msg_ready, 0);

    // R3 rejections
    do_setup_data(0, 2);
    chk("R3 err zero pages", setup_err, 1);
    chk("R3 still unready", data_ready, 0);
    do_setup_data(3, 9);
    chk("R3 err over max", setup_err, 1);
    chk("R3 no done", setup_done, 0);

    // R1 R2 accepted setup
    do_setup_data(3, 2);
    m_pages[0] = 3; m_pages[1] = 2; m_cnt[0] = 0; m_cnt[1] = 0;
    chk("R2 done", setup_done, 1);
    chk("R2 ready", data_ready, 1);
    chk("R2 init_pulse", init_pulse, 3'b011);
    chk("R1 req_log2 96 entries", req_log2, 7);
    chk("R1 cmp_log2 256 entries", cmp_log2, 8);
    chk("R2 msg untouched", msg_ready, 0);
    cyc;
    chk("R2 pulse drops", init_pulse, 0);

    // R4 availability edges
    req_prod_sh = 0; #1;
    chk("R4 equal no avail", req_avail, 0);
    req_prod_sh = 256; #1;
    chk("R4 gap 256 no avail", req_avail, 0);
    req_prod_sh = 255; #1;
    chk("R4 gap 255 avail", req_avail, 1);
    chk("R5 first req addr", req_addr, exp_addr(0, 0));
    req_prod_sh = 32'hFFFF_FFFF; #1;
    chk("R4 negative gap no avail", req_avail, 0);
    req_take = 1; cyc; req_take = 0;
    req_flush = 1; cyc; req_flush = 0;
    chk("R4 take ignored without avail", req_cons_wb, 0);

    // random mix: R4 R5 R6 R7
    for (int it = 0; it < 600; it++) begin
      int op = int'($urandom % 5);
      case (op)
        0, 1: begin
          req_prod_sh = m_cnt[0] + 1 + ($urandom % 255); #1;
          chk("R4 avail", req_avail, 1);
          chk("R5 req addr", req_addr, exp_addr(0, m_cnt[0]));
          req_take = 1; cyc; req_take = 0; m_cnt[0]++;
        end
        2: begin
          chk("R5 cmp addr", cmp_addr, exp_addr(1, m_cnt[1]));
          cmp_put = 1; cyc; cmp_put = 0; m_cnt[1]++;
        end
        3: begin
          req_prod_sh = m_cnt[0] + 256 + ($urandom % 4000); #1;
          chk("R4 beyond cap", req_avail, 0);
          req_flush = 1; cyc; req_flush = 0;
          chk("R6 req publish vld", req_cons_wb_vld, 1);
          chk("R6 req publish val", req_cons_wb, m_cnt[0]);
        end
        default: begin
          cmp_flush = 1; cyc; cmp_flush = 0;
          chk("R7 cmp publish vld", cmp_prod_wb_vld, 1);
          chk("R7 cmp publish val", cmp_prod_wb, m_cnt[1]);
        end
      endcase
    end

    // R3 R9 message setup
    do_setup_msg(5);
    chk("R3 msg over max err", setup_err, 1);
    chk("R3 msg stays unready", msg_ready, 0);
    do_setup_msg(0);
    chk("R3 msg zero err", setup_err, 1);
    do_setup_msg(3);
    m_pages[2] = 3; m_cnt[2] = 0;
    chk("R9 msg done", setup_done, 1);
    chk("R9 msg init", init_pulse, 3'b100);
    chk("R1 msg_log2", msg_log2, 7);

    // R8 room edges (window is mask+1 = 128)
    msg_prod_sh = 10; msg_cons_sh = 10 - 127; #1;
    chk("R8 gap 127 room", msg_room, 1);
    chk("R8 msg addr", msg_addr, exp_addr(2, 0));
    msg_put = 1; cyc; msg_put = 0; m_cnt[2]++;
    chk("R8 publish vld", msg_prod_wb_vld, 1);
    chk("R8 publish val", msg_prod_wb, 1);
    msg_cons_sh = 10 - 128; #1;
    chk("R8 gap 128 no room", msg_room, 0);
    msg_put = 1; cyc; msg_put = 0;
    chk("R8 no publish", msg_prod_wb_vld, 0);
    chk("R8 addr unchanged", msg_addr, exp_addr(2, 1));
    msg_prod_sh = 5; msg_cons_sh = 32'hFFFF_FFF0; #1;
    chk("R8 wrapped gap room", msg_room, 1);
    for (int it = 0; it < 150; it++) begin
      chk("R8 msg addr walk", msg_addr, exp_addr(2, m_cnt[2]));
      msg_put = 1; cyc; msg_put = 0; m_cnt[2]++;
      chk("R8 walk publish", msg_prod_wb, m_cnt[2]);
    end

    // R2 re-setup keeps message ring
    do_setup_data(8, 1);
    m_pages[0] = 8; m_pages[1] = 1; m_cnt[0] = 0; m_cnt[1] = 0;
    chk("R1 req_log2 256 entries", req_log2, 8);
    chk("R1 cmp_log2 128 entries", cmp_log2, 7);
    chk("R2 msg kept", msg_ready, 1);
    req_prod_sh = 1; #1;
    chk("R2 counter cleared", req_addr, exp_addr(0, 0));
    chk("R2 cmp counter cleared", cmp_addr, exp_addr(1, 0));
    do_setup_data(9, 1);
    chk("R3 err when ready", setup_err, 1);
    chk("R3 log2 kept", req_log2, 8);
    chk("R3 ready kept", data_ready, 1);

    // R10 cleanup
    clr = 1; cyc; clr = 0;
    chk("R10 data unready", data_ready, 0);
    chk("R10 msg unready", msg_ready, 0);
    chk("R10 log2 cleared", req_log2, 0);
    chk("R10 no room", msg_room, 0);
    do_setup_data(2, 2);
    req_prod_sh = 40; #1;
    chk("R10 avail after setup", req_avail, 1);
    chk("R10 table cleared", req_addr, 0);

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule